// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a free-running up-counter with a software-programmed wrap point. It advances once per clock and returns to zero after it reaches the programmed limit, so the interval is the limit plus one cycles. Each wrap sets a sticky pending flag. Software clears that flag by writing the control register with the flag bit low. When interrupts are enabled, the pending flag drives a registered interrupt line. In watchdog mode, each wrap also produces a one-cycle reset-request pulse.

Software reaches the count, control and limit registers through a plain address / write-enable / write-data / read-data port. An optional control bit makes the counter freeze while an external processor-halt input is high. Software cannot stop the counter any other way. Writing zero to the control register only silences the interrupt. To restart an interval, software writes the count register directly.

Top module: `lc_interval_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, count, control and limit all become 0, and `irq` and `wdog_rst_req` become 0.
- R2: Address 0 selects count, address 1 selects control and address 2 selects limit. Address 3 reads 0 and ignores writes. Count and limit read back exactly what was written. Control bit 0 is interrupt enable, bit 1 is halt gating, bit 2 is watchdog mode and bit 3 is the pending flag; control bits 31..4 read 0.
- R3: When not frozen, count increments by one each cycle. When count equals limit, the next value is 0 instead, giving a period of limit+1. With limit 0, count stays at 0 and matches on every cycle.
- R4: A match (count equal to limit on an advancing cycle) sets the pending flag. The flag keeps its value until a control write, which loads it from data bit 3; a write with bit 3 high sets it.
- R5: When control bit 1 is 1 and `cpu_halted` is 1, count holds its value. When bit 1 is 0, `cpu_halted` has no effect on counting.
- R6: `irq` is 1 exactly one cycle after the pending flag and interrupt enable are both 1. It stays 1 while both remain 1.
- R7: With interrupt enable 0, the pending flag still sets on a match but `irq` stays 0. Writing 0 to control lowers `irq` one cycle later, and the counter keeps advancing.
- R8: If a match and a control write with bit 3 low fall in the same cycle, the pending flag ends up 1.
- R9: With control bit 2 set, a match drives `wdog_rst_req` high for the cycle after it and also sets the pending flag. `wdog_rst_req` is 0 whenever watchdog mode was off at the match.
- R10: A count write takes precedence over the increment or wrap in that cycle. Counting then resumes from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_halted | input | 1 | Processor halt indication; freezes counting when halt gating is on |
| reg_addr | input | 2 | Register select: 0 count, 1 control, 2 limit |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| irq | output | 1 | Registered interrupt: pending AND enable |
| wdog_rst_req | output | 1 | One-cycle reset request after a match in watchdog mode |

## Verification
The following properties are checked by assertions on every cycle:
- the wrap to zero after a match and the hold while halt-gated;
- the pending flag setting after every match and staying sticky between control writes;
- `irq` following pending-and-enable one cycle later, and staying low when enable is clear;
- reset requests occurring only in watchdog mode.

Some behaviours can only be shown by the bench's scenarios:
- the exact interval length for a range of limits, including 0 and the all-ones limit;
- field positions seen through the read port;
- a match winning over a simultaneous clear;
- the counter continuing to run after control is written to zero.

// File: rtl/lct_pkg.sv
// Shared definitions for the limit-compare interval timer.
// Assumes a two-bit register address and a four-bit control field.
package lct_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_LIMIT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Packed so that pend lands on bit 3 and ie on bit 0.
    typedef struct packed {
        logic pend;   // bit 3: sticky match flag
        logic wdog;   // bit 2: watchdog mode
        logic gate;   // bit 1: freeze while processor halted
        logic ie;     // bit 0: interrupt enable
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/lct_decode.sv
// Register address decode and read multiplexer.
// Produces one write strobe per register and a combinational read value.
// Assumes DATA_W >= CTRL_W; control bits above the field read zero.
module lct_decode
    import lct_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] count,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] limit,
    output logic              count_we,
    output logic              ctrl_we,
    output logic              limit_we,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - CTRL_W;

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // Write strobe generation per register
    always_comb begin
        count_we = we && (sel == SEL_COUNT);
        ctrl_we  = we && (sel == SEL_CTRL);
        limit_we = we && (sel == SEL_LIMIT);
    end

    // Read data selection
    always_comb begin
        unique case (sel)
            SEL_COUNT: rdata = count;
            SEL_CTRL:  rdata = {{PAD_W{1'b0}}, ctrl};
            SEL_LIMIT: rdata = limit;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/lct_counter.sv
// Up-counter with limit compare and the limit register.
// Advances each cycle unless halt gating is on and the halt input is high.
// On an advancing cycle with count == limit it wraps to zero and flags a match.
// A software count write overrides the advance in that cycle.
module lct_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              gate_en,
    input  logic              count_we,
    input  logic              limit_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] limit_o,
    output logic              match_o
);
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] limit_q;
    logic              advance;
    logic              at_limit;

    assign advance  = !(gate_en && halt);
    assign at_limit = (count_q == limit_q);
    assign match_o  = advance && at_limit;
    assign count_o  = count_q;
    assign limit_o  = limit_q;

    // Count register: write, wrap or increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (count_we)
            count_q <= wdata;
        else if (advance)
            count_q <= at_limit ? '0 : count_q + 1'b1;
    end

    // Limit register: software-loaded only
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_q <= '0;
        else if (limit_we)
            limit_q <= wdata;
    end

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && at_limit && !count_we) |=> (count_q == '0));

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && halt && !count_we) |=> $stable(count_q));

    // R10
    count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_we |=> (count_q == $past(wdata)));
endmodule

// File: rtl/lct_ctrl.sv
// Control register, sticky pending flag and registered outputs.
// Assumes the match input is a single-cycle strobe per advancing compare hit.
// A match sets pending even when a control write clears it in the same cycle.
module lct_ctrl
    import lct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              match,
    output ctrl_t             ctrl_o,
    output logic              irq_o,
    output logic              wdog_o
);
    ctrl_t ctrl_q;
    logic  irq_q;
    logic  wdog_q;

    assign ctrl_o = ctrl_q;
    assign irq_o  = irq_q;
    assign wdog_o = wdog_q;

    // Control fields: software write, then a match forces pending high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_we)
                ctrl_q <= ctrl_t'(wdata);
            if (match)
                ctrl_q.pend <= 1'b1;
        end
    end

    // Interrupt line: registered AND of pending and enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= ctrl_q.pend & ctrl_q.ie;
    end

    // Reset request: one cycle after a match in watchdog mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdog_q <= 1'b0;
        else
            wdog_q <= match & ctrl_q.wdog;
    end

    // R8
    match_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> ctrl_q.pend);

    // R4
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !ctrl_we) |=> $stable(ctrl_q.pend));

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.pend && ctrl_q.ie) |=> irq_q);

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.ie |=> !irq_q);

    // R9
    wdog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.wdog |=> !wdog_q);
endmodule

// File: rtl/lc_interval_timer.sv
// Limit-compare interval timer: top level.
// Ties the register decode, counter and control blocks together.
// Assumes a single-cycle register access with combinational read data.
module lc_interval_timer
    import lct_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_halted,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              wdog_rst_req
);
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] limit;
    ctrl_t             ctrl;
    logic              count_we;
    logic              ctrl_we;
    logic              limit_we;
    logic              match;

    lct_decode #(.DATA_W(DATA_W)) u_decode (
        .addr     (reg_addr),
        .we       (reg_we),
        .count    (count),
        .ctrl     (ctrl),
        .limit    (limit),
        .count_we (count_we),
        .ctrl_we  (ctrl_we),
        .limit_we (limit_we),
        .rdata    (reg_rdata)
    );

    lct_counter #(.DATA_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (cpu_halted),
        .gate_en  (ctrl.gate),
        .count_we (count_we),
        .limit_we (limit_we),
        .wdata    (reg_wdata),
        .count_o  (count),
        .limit_o  (limit),
        .match_o  (match)
    );

    lct_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .wdata   (reg_wdata[CTRL_W-1:0]),
        .match   (match),
        .ctrl_o  (ctrl),
        .irq_o   (irq),
        .wdog_o  (wdog_rst_req)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && !wdog_rst_req));
endmodule

// File: tb/lc_interval_timer_test.sv
`timescale 1ns/100ps
module lc_interval_timer_test;
    localparam logic [1:0] A_CNT = 2'd0;
    localparam logic [1:0] A_CTL = 2'd1;
    localparam logic [1:0] A_LIM = 2'd2;
    localparam int NVEC = 10;
    // {limit, cycles waited after setup}
    localparam logic [63:0] VEC [NVEC] = '{
        {32'd0,   32'd5},
        {32'd1,   32'd4},
        {32'd3,   32'd2},
        {32'd3,   32'd3},
        {32'd3,   32'd10},
        {32'd7,   32'd100},
        {32'd9,   32'd9},
        {32'd9,   32'd8},
        {32'd100, 32'd250},
        {32'hFFFF_FFFF, 32'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_halted = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        wdog_rst_req;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    lc_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .cpu_halted(cpu_halted),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .wdog_rst_req(wdog_rst_req)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the following posedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, c1;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(A_CNT, v); chk("R1 count", v, 0);
        rd(A_CTL, v); chk("R1 ctrl", v, 0);
        rd(A_LIM, v); chk("R1 limit", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wdog", wdog_rst_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 readback, unmapped address, field layout
        wr(A_LIM, 32'h1234_5678);
        rd(A_LIM, v); chk("R2 limit readback", v, 32'h1234_5678);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd3, v); chk("R2 unmapped reads 0", v, 0);
        rd(A_LIM, v); chk("R2 limit untouched", v, 32'h1234_5678);
        wr(A_LIM, 32'hFFFF_FFFF);
        wr(A_CTL, 32'hFFFF_FFF7);
        rd(A_CTL, v); chk("R2 ctrl upper bits 0", v, 32'h7);
        wr(A_CTL, 0);
        // R10 count write then resume
        wr(A_CNT, 32'h0000_0400);
        rd(A_CNT, v); chk("R10 count written", v, 32'h400);
        repeat (4) @(negedge clk);
        rd(A_CNT, v); chk("R10 resumes from written", v, 32'h404);

        // R3 R4 vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] lim, n;
            logic [63:0] ecnt;
            lim = VEC[i][63:32];
            n   = VEC[i][31:0];
            wr(A_LIM, lim);
            wr(A_CNT, 0);
            wr(A_CTL, 0);
            repeat (n) @(negedge clk);
            ecnt = (64'd1 + 64'(n)) % (64'(lim) + 64'd1);
            rd(A_CNT, v); chk("R3 count after interval", v, ecnt[31:0]);
            rd(A_CTL, v); chk("R4 pending after interval", v, (n >= lim) ? 32'h8 : 32'h0);
        end

        // R5 halt gating
        cpu_halted = 1'b1;
        wr(A_LIM, 32'hFFFF_FFFF);
        wr(A_CTL, 32'h2);
        wr(A_CNT, 32'd100);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R5 held while halted", v, 32'd100);
        wr(A_CTL, 32'h0);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R5 halt ignored when gate off", v, 32'd105);
        cpu_halted = 1'b0;

        // R6 match-driven interrupt timing
        wr(A_LIM, 32'd3);
        wr(A_CNT, 0);
        wr(A_CTL, 32'h1);
        repeat (2) @(negedge clk);
        rd(A_CTL, v); chk("R6 no pending before match", v, 32'h1);
        @(negedge clk);
        rd(A_CTL, v); chk("R4 pending on match", v, 32'h9);
        chk("R6 irq not yet", irq, 0);
        @(negedge clk);
        chk("R6 irq one cycle later", irq, 1);

        // R4 R6 software-set pending, R7 clear
        wr(A_LIM, 32'hFFFF_FFFF);
        wr(A_CTL, 32'h9);
        wr(A_CTL, 32'h9);
        repeat (3) @(negedge clk);
        chk("R6 irq stays asserted", irq, 1);
        wr(A_CTL, 32'h1);
        chk("R6 irq registered after clear", irq, 1);
        rd(A_CTL, v); chk("R4 pending cleared", v, 32'h1);
        @(negedge clk);
        chk("R6 irq drops", irq, 0);

        // R7 masked pending
        wr(A_CTL, 32'h8);
        repeat (3) @(negedge clk);
        chk("R7 masked irq low", irq, 0);
        rd(A_CTL, v); chk("R7 pending kept while masked", v, 32'h8);
        wr(A_CTL, 32'h9);
        @(negedge clk);
        chk("R7 irq up before disable", irq, 1);
        wr(A_CTL, 32'h0);
        @(negedge clk);
        chk("R7 irq low after control zero", irq, 0);
        rd(A_CNT, c1);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R7 counter still runs", v, c1 + 32'd3);

        // R8 match beats same-cycle clear
        cpu_halted = 1'b1;
        wr(A_CTL, 32'h2);
        wr(A_CNT, 32'd3);
        wr(A_LIM, 32'd3);
        rd(A_CTL, v); chk("R8 pending clear before", v, 32'h2);
        cpu_halted = 1'b0;
        wr(A_CTL, 32'h0);
        rd(A_CTL, v); chk("R8 match wins over clear", v, 32'h8);
        rd(A_CNT, v); chk("R3 wrapped at match", v, 0);

        // R9 watchdog pulse
        cpu_halted = 1'b1;
        wr(A_LIM, 32'hFFFF_FFFF);
        wr(A_CTL, 32'h6);
        wr(A_CNT, 32'd5);
        wr(A_LIM, 32'd5);
        chk("R9 no request before match", wdog_rst_req, 0);
        cpu_halted = 1'b0;
        @(negedge clk);
        chk("R9 request after match", wdog_rst_req, 1);
        rd(A_CTL, v); chk("R9 pending also set", v, 32'hE);
        @(negedge clk);
        chk("R9 request one cycle only", wdog_rst_req, 0);
        rd(A_CNT, v); chk("R9 count resumed", v, 32'd1);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rd(A_CNT, v); chk("R1 count after reset", v, 0);
        rd(A_CTL, v); chk("R1 ctrl after reset", v, 0);
        rd(A_LIM, v); chk("R1 limit after reset", v, 0);
        chk("R1 wdog after reset", wdog_rst_req, 0);

        done = 1'b1;
        finish_run();
    end
endmodule